// File: doc/BRIEF.md
# Local Configuration-Space Read Command Handler

This block sits on the client side of a byte-oriented sideband management link. It serves one command: a read of the local configuration space. The link front end has already deframed the write phase. It presents the write length, the read length, the command code and the three configuration-address bytes in parallel, qualified by a one-cycle `frm_valid`. The handler checks that the frame is legal and splits the 24-bit address into bus, device, function and register-offset fields. It then either issues a single read on an internal register-space port, or answers straight away when the bus number selects no space.

The answer goes back one byte per cycle. A completion code always comes first, followed by one, two or four data bytes with the least significant byte first. The read length of the frame sets the number of data bytes. A read that misses (the register is not implemented or is hidden) answers with the invalid-request code and zero data. The frame check sequence, the bit-level signalling and the register space itself lie outside the block.

The control is a four-state machine:
- **IDLE**: waits for a frame and holds `frm_ready` high.
- **ISSUE**: drives the one-cycle request.
- **WAIT**: holds until the register port acknowledges.
- **SEND**: streams the response.

The transitions are:
- IDLE→ISSUE: a legal frame on bus 0 or 1.
- IDLE→SEND: a legal frame on any other bus.
- ISSUE→SEND or WAIT→SEND: acknowledge seen.
- ISSUE→WAIT: no acknowledge in the request cycle.
- SEND→IDLE: after the last byte.

An illegal frame leaves the machine in IDLE.

Top module: `cfgrd_handler`

## Requirements
- R1: After reset `frm_ready` is 1, and `rsp_valid`, `rsp_last` and `rq_valid` are 0.
- R2: A legal frame has command 0xE1, write length 0x05, read length 0x02, 0x03 or 0x05, and bus (address bits [23:20]) equal to 0 or 1. Address byte `frm_addr_lo` carries bits [7:0] and `frm_addr_hi` carries bits [23:16]. Such a frame raises `rq_valid` for exactly one cycle, in the cycle after the frame is taken. The request carries `rq_space` = bus bit 0, `rq_dev` = bits [19:15], `rq_func` = bits [14:12] and `rq_reg` = bits [11:0].
- R3: A frame with a wrong command code, a wrong write length or an unsupported read length is dropped. It raises no request and produces no response byte.
- R4: A legal frame whose bus is neither 0 nor 1 raises no request. Its response starts in the cycle after the frame is taken and is code 0x40 followed by zero data bytes.
- R5: When `rq_ack` is high in a cycle, the first response byte appears in the next cycle. The remaining bytes follow on consecutive cycles with `rsp_valid` high.
- R6: A response is the completion code followed by 1, 2 or 4 data bytes for read length 0x02, 0x03 or 0x05. `rsp_last` is high only on its final byte.
- R7: Data bytes of `rq_data` go out least significant byte first.
- R8: If `rq_hit` is 1 at the acknowledge, the code is 0x40 and the data is `rq_data`. If `rq_hit` is 0, the code is 0x90 and every data byte is 0x00.
- R9: `frm_ready` is low from the cycle after a frame is taken until the cycle after the last response byte. Any frame offered while it is low is ignored.
- R10: While the acknowledge is outstanding the handler waits without limit, and `rsp_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Decoded write-phase frame present this cycle |
| frm_ready | output | 1 | Handler idle and able to take a frame |
| frm_wr_len | input | 8 | Write length byte |
| frm_rd_len | input | 8 | Read length byte |
| frm_cmd | input | 8 | Command code byte |
| frm_addr_lo | input | 8 | Configuration address bits [7:0] (first on the wire) |
| frm_addr_mid | input | 8 | Configuration address bits [15:8] |
| frm_addr_hi | input | 8 | Configuration address bits [23:16] |
| rq_valid | output | 1 | One-cycle register read request |
| rq_space | output | 1 | 0: I/O-hub device space, 1: remaining uncore space |
| rq_dev | output | 5 | Device number |
| rq_func | output | 3 | Function number |
| rq_reg | output | 12 | Register offset |
| rq_ack | input | 1 | Register port read complete |
| rq_hit | input | 1 | Register exists and is visible |
| rq_data | input | 32 | Read data, valid with `rq_ack` |
| rsp_valid | output | 1 | Response byte present |
| rsp_byte | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |

## Verification
Every timing point is counted from the clock edge that takes the frame. The request is due one cycle later. A bad-bus response starts one cycle later. A normal response starts one cycle after the acknowledge, which the bench responder places 0 to 20 cycles after the request. The bench model keeps an exact count of silent cycles and a queue of expected bytes, and compares `frm_ready`, `rq_valid`, `rsp_valid`, `rsp_byte` and `rsp_last` on every falling edge. A slip of a single cycle therefore shows up as a mismatch in that cycle.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

    localparam int BYTE_W     = 8;
    localparam int DATA_BYTES = 4;
    localparam int DATA_W     = DATA_BYTES * BYTE_W;
    localparam int ADDR_W     = 24;
    localparam int BUS_W      = 4;
    localparam int DEV_W      = 5;
    localparam int FUNC_W     = 3;
    localparam int OFFS_W     = 12;
    localparam int IDX_W      = $clog2(DATA_BYTES + 1);

    localparam logic [BYTE_W-1:0] CMD_CFG_LOCAL = 8'hE1;
    localparam logic [BYTE_W-1:0] WR_LEN_LEGAL  = 8'h05;
    localparam logic [BYTE_W-1:0] RD_LEN_ONE    = 8'h02;
    localparam logic [BYTE_W-1:0] RD_LEN_TWO    = 8'h03;
    localparam logic [BYTE_W-1:0] RD_LEN_FOUR   = 8'h05;
    localparam logic [BYTE_W-1:0] CC_PASS       = 8'h40;
    localparam logic [BYTE_W-1:0] CC_BAD_REG    = 8'h90;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_SEND
    } cfgrd_state_e;

    typedef struct packed {
        logic              space;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [OFFS_W-1:0] offs;
    } cfgrd_req_t;

endpackage

// File: rtl/cfgrd_decode.sv
module cfgrd_decode
    import cfgrd_pkg::*;
(
    input  logic [BYTE_W-1:0] wr_len,
    input  logic [BYTE_W-1:0] rd_len,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [ADDR_W-1:0] addr,
    output logic              legal,
    output logic              bus_ok,
    output cfgrd_req_t        req,
    output logic [IDX_W-1:0]  nbytes
);

    localparam int OFFS_LO = 0;
    localparam int FUNC_LO = OFFS_LO + OFFS_W;
    localparam int DEV_LO  = FUNC_LO + FUNC_W;
    localparam int BUS_LO  = DEV_LO + DEV_W;

    logic             len_ok;
    logic [BUS_W-1:0] bus;

    always_comb begin
        len_ok = 1'b1;
        unique case (rd_len)
            RD_LEN_ONE:  nbytes = IDX_W'(1);
            RD_LEN_TWO:  nbytes = IDX_W'(2);
            RD_LEN_FOUR: nbytes = IDX_W'(4);
            default: begin
                nbytes = '0;
                len_ok = 1'b0;
            end
        endcase
    end

    assign bus      = addr[BUS_LO +: BUS_W];
    assign bus_ok   = (bus == BUS_W'(0)) || (bus == BUS_W'(1));
    assign legal    = (cmd == CMD_CFG_LOCAL) && (wr_len == WR_LEN_LEGAL) && len_ok;

    assign req.space = bus[0];
    assign req.dev   = addr[DEV_LO  +: DEV_W];
    assign req.func  = addr[FUNC_LO +: FUNC_W];
    assign req.offs  = addr[OFFS_LO +: OFFS_W];

endmodule

// File: rtl/cfgrd_lane_mux.sv
module cfgrd_lane_mux
    import cfgrd_pkg::*;
#(
    parameter int LANES = DATA_BYTES
) (
    input  logic [BYTE_W-1:0]       code,
    input  logic [LANES*BYTE_W-1:0] data,
    input  logic [IDX_W-1:0]        idx,
    output logic [BYTE_W-1:0]       out_byte
);

    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = data[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        out_byte = (idx == '0) ? code : '0;
        for (int i = 0; i < LANES; i++) begin
            if (idx == IDX_W'(i + 1)) begin
                out_byte = lane[i];
            end
        end
    end

endmodule

// File: rtl/cfgrd_fsm.sv
module cfgrd_fsm
    import cfgrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              legal,
    input  logic              bus_ok,
    input  cfgrd_req_t        req_in,
    input  logic [IDX_W-1:0]  nbytes_in,
    input  logic              rq_ack,
    input  logic              rq_hit,
    input  logic [DATA_W-1:0] rq_data,
    output logic              frm_ready,
    output logic              rq_valid,
    output cfgrd_req_t        req_q,
    output logic [BYTE_W-1:0] code_q,
    output logic [DATA_W-1:0] data_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              rsp_valid,
    output logic              rsp_last
);

    cfgrd_state_e     state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             take;
    logic             done;

    assign take = frm_valid && legal && (state_q == ST_IDLE);
    assign done = (idx_q == cnt_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take)   state_d = bus_ok ? ST_ISSUE : ST_SEND;
            ST_ISSUE: state_d = rq_ack ? ST_SEND : ST_WAIT;
            ST_WAIT:  if (rq_ack) state_d = ST_SEND;
            ST_SEND:  if (done)   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            code_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        req_q  <= req_in;
                        cnt_q  <= nbytes_in;
                        idx_q  <= '0;
                        code_q <= CC_PASS;
                        data_q <= '0;
                    end
                end
                ST_ISSUE, ST_WAIT: begin
                    if (rq_ack) begin
                        code_q <= rq_hit ? CC_PASS : CC_BAD_REG;
                        data_q <= rq_hit ? rq_data : '0;
                    end
                end
                ST_SEND: begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            endcase
        end
    end

    always_comb begin
        frm_ready = 1'b0;
        rq_valid  = 1'b0;
        rsp_valid = 1'b0;
        rsp_last  = 1'b0;
        unique case (state_q)
            ST_IDLE:  frm_ready = 1'b1;
            ST_ISSUE: rq_valid  = 1'b1;
            ST_WAIT:  ;
            ST_SEND: begin
                rsp_valid = 1'b1;
                rsp_last  = done;
            end
        endcase
    end

endmodule

// File: rtl/cfgrd_handler.sv
module cfgrd_handler
    import cfgrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    output logic              frm_ready,
    input  logic [BYTE_W-1:0] frm_wr_len,
    input  logic [BYTE_W-1:0] frm_rd_len,
    input  logic [BYTE_W-1:0] frm_cmd,
    input  logic [BYTE_W-1:0] frm_addr_lo,
    input  logic [BYTE_W-1:0] frm_addr_mid,
    input  logic [BYTE_W-1:0] frm_addr_hi,
    output logic              rq_valid,
    output logic              rq_space,
    output logic [DEV_W-1:0]  rq_dev,
    output logic [FUNC_W-1:0] rq_func,
    output logic [OFFS_W-1:0] rq_reg,
    input  logic              rq_ack,
    input  logic              rq_hit,
    input  logic [DATA_W-1:0] rq_data,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte,
    output logic              rsp_last
);

    logic              dec_legal;
    logic              dec_bus_ok;
    cfgrd_req_t        dec_req;
    logic [IDX_W-1:0]  dec_nbytes;
    cfgrd_req_t        req_q;
    logic [BYTE_W-1:0] code_q;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  idx_q;

    cfgrd_decode u_decode (
        .wr_len (frm_wr_len),
        .rd_len (frm_rd_len),
        .cmd    (frm_cmd),
        .addr   ({frm_addr_hi, frm_addr_mid, frm_addr_lo}),
        .legal  (dec_legal),
        .bus_ok (dec_bus_ok),
        .req    (dec_req),
        .nbytes (dec_nbytes)
    );

    cfgrd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .legal     (dec_legal),
        .bus_ok    (dec_bus_ok),
        .req_in    (dec_req),
        .nbytes_in (dec_nbytes),
        .rq_ack    (rq_ack),
        .rq_hit    (rq_hit),
        .rq_data   (rq_data),
        .frm_ready (frm_ready),
        .rq_valid  (rq_valid),
        .req_q     (req_q),
        .code_q    (code_q),
        .data_q    (data_q),
        .idx_q     (idx_q),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last)
    );

    cfgrd_lane_mux #(.LANES(DATA_BYTES)) u_mux (
        .code     (code_q),
        .data     (data_q),
        .idx      (idx_q),
        .out_byte (rsp_byte)
    );

    assign rq_space = req_q.space;
    assign rq_dev   = req_q.dev;
    assign rq_func  = req_q.func;
    assign rq_reg   = req_q.offs;

endmodule

// File: rtl/cfgrd_handler_chk.sv
module cfgrd_handler_chk
    import cfgrd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frm_valid,
    input logic              frm_ready,
    input logic [BYTE_W-1:0] frm_cmd,
    input logic              rq_valid,
    input logic              rsp_valid,
    input logic [BYTE_W-1:0] rsp_byte,
    input logic              rsp_last
);

    AST_RQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |=> !rq_valid); // R2

    AST_BAD_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_ready && frm_cmd != CMD_CFG_LOCAL) |=> (!rq_valid && !rsp_valid)); // R3

    AST_NO_RQ_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rq_valid); // R5

    AST_CODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (rsp_byte == CC_PASS || rsp_byte == CC_BAD_REG)); // R6

    AST_LAST_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid); // R6

    AST_LAST_ENDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> !rsp_valid); // R6

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || rq_valid) |-> !frm_ready); // R9

endmodule

bind cfgrd_handler cfgrd_handler_chk u_chk (.*);

// File: tb/cfgrd_handler_tb_top.sv
module cfgrd_handler_tb_top;
    import cfgrd_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_ready;
    logic [7:0]  frm_wr_len = '0, frm_rd_len = '0, frm_cmd = '0;
    logic [7:0]  frm_addr_lo = '0, frm_addr_mid = '0, frm_addr_hi = '0;
    logic        rq_valid, rq_space;
    logic [4:0]  rq_dev;
    logic [2:0]  rq_func;
    logic [11:0] rq_reg;
    logic        rq_ack = 1'b0, rq_hit = 1'b0;
    logic [31:0] rq_data = '0;
    logic        rsp_valid, rsp_last;
    logic [7:0]  rsp_byte;

    cfgrd_handler dut_i (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    int wait_cnt = 0, rq_due = 0, rq_seen = 0, rq_exp = 0, pos = 0;
    bit first_ready = 1'b0;
    logic [20:0] exp_req = '0;
    int rsp_delay = 0;
    bit rsp_hit = 1'b1;
    logic [31:0] rsp_word = '0;
    bit r_act = 1'b0;
    int r_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model and responder, evaluated on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            rq_ack = 1'b0;
            if (rq_due > 0) begin
                rq_due--;
                chk(rq_valid == (rq_due == 0), "R2 request pulse timing", 32'(rq_valid), 32'(rq_due == 0));
            end else begin
                chk(rq_valid == 1'b0, "R3 R4 no stray request", 32'(rq_valid), 0);
            end
            if (rq_valid) begin
                rq_seen++;
                chk({rq_space, rq_dev, rq_func, rq_reg} == exp_req, "R2 request fields",
                    32'({rq_space, rq_dev, rq_func, rq_reg}), 32'(exp_req));
                r_act = 1'b1;
                r_cnt = rsp_delay;
            end
            if (r_act) begin
                if (r_cnt == 0) begin
                    rq_ack  = 1'b1;
                    rq_hit  = rsp_hit;
                    rq_data = rsp_word;
                    r_act   = 1'b0;
                end else begin
                    r_cnt--;
                end
            end
            if (first_ready) begin
                chk(frm_ready == 1'b1, "R9 ready when frame offered", 32'(frm_ready), 1);
                first_ready = 1'b0;
            end else begin
                chk(frm_ready == (exp_q.size() == 0 && wait_cnt == 0), "R9 ready level",
                    32'(frm_ready), 32'(exp_q.size() == 0 && wait_cnt == 0));
            end
            if (wait_cnt > 0) begin
                wait_cnt--;
                chk(rsp_valid == 1'b0, "R10 silent while waiting", 32'(rsp_valid), 0);
            end else if (exp_q.size() > 0) begin
                chk(rsp_valid == 1'b1, "R5 consecutive stream", 32'(rsp_valid), 1);
                if (pos == 0)
                    chk(rsp_byte == exp_q[0], "R8 completion code first", 32'(rsp_byte), 32'(exp_q[0]));
                else
                    chk(rsp_byte == exp_q[0], "R7 data byte order", 32'(rsp_byte), 32'(exp_q[0]));
                chk(rsp_last == (exp_q.size() == 1), "R6 last flag", 32'(rsp_last), 32'(exp_q.size() == 1));
                void'(exp_q.pop_front());
                pos++;
                if (exp_q.size() == 0) pos = 0;
            end else begin
                chk(rsp_valid == 1'b0 && rsp_last == 1'b0, "R3 no response", 32'(rsp_valid), 0);
            end
        end
    end

    task automatic offer(input logic [7:0] wr, input logic [7:0] rd, input logic [7:0] cmd,
                         input logic [23:0] addr, input int d, input bit hit, input logic [31:0] word);
        bit busy, legal;
        int n;
        @(posedge clk); #1;
        frm_wr_len = wr; frm_rd_len = rd; frm_cmd = cmd;
        {frm_addr_hi, frm_addr_mid, frm_addr_lo} = addr;
        frm_valid = 1'b1;
        busy  = (exp_q.size() != 0) || (wait_cnt != 0);
        legal = (cmd == 8'hE1) && (wr == 8'h05) && (rd == 8'h02 || rd == 8'h03 || rd == 8'h05);
        n = (rd == 8'h02) ? 1 : (rd == 8'h03) ? 2 : 4;
        if (!busy && legal) begin
            first_ready = 1'b1;
            if (addr[23:20] < 4'd2) begin
                rq_due = 2;
                rq_exp++;
                exp_req = {addr[20], addr[19:15], addr[14:12], addr[11:0]};
                rsp_delay = d; rsp_hit = hit; rsp_word = word;
                wait_cnt = d + 2;
                exp_q.push_back(hit ? 8'h40 : 8'h90);
                for (int i = 0; i < n; i++) exp_q.push_back(hit ? word[8*i +: 8] : 8'h00);
            end else begin
                wait_cnt = 1;
                exp_q.push_back(8'h40);
                for (int i = 0; i < n; i++) exp_q.push_back(8'h00);
            end
        end
        @(posedge clk); #1;
        frm_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || wait_cnt != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(frm_ready == 1'b1, "R1 reset ready", 32'(frm_ready), 1);
        chk(!rsp_valid && !rsp_last && !rq_valid, "R1 reset outputs quiet",
            32'({rsp_valid, rsp_last, rq_valid}), 0);

        // R2 R7 R8: bus 0, four data bytes, immediate acknowledge
        offer(8'h05, 8'h05, 8'hE1, {4'h0, 5'd17, 3'd5, 12'hA5C}, 0, 1'b1, 32'hA1B2C3D4);
        drain();
        // R2 R6 R5: bus 1, two data bytes, acknowledge after 2 cycles
        offer(8'h05, 8'h03, 8'hE1, {4'h1, 5'd3, 3'd2, 12'h010}, 2, 1'b1, 32'h11223344);
        drain();
        // R8 miss: invalid register, one data byte
        offer(8'h05, 8'h02, 8'hE1, {4'h1, 5'd31, 3'd7, 12'hFFF}, 5, 1'b0, 32'hDEADBEEF);
        drain();
        // R4 bad bus: zero data with passing code, no request
        offer(8'h05, 8'h05, 8'hE1, {4'h7, 5'd1, 3'd1, 12'h004}, 0, 1'b1, 32'hFFFFFFFF);
        drain();
        offer(8'h05, 8'h02, 8'hE1, {4'hF, 5'd0, 3'd0, 12'h000}, 0, 1'b1, 32'h0);
        drain();
        // R3 illegal frames: command, write length, read length
        offer(8'h05, 8'h05, 8'hE2, {4'h0, 5'd1, 3'd0, 12'h100}, 0, 1'b1, 32'h1);
        drain();
        offer(8'h04, 8'h05, 8'hE1, {4'h0, 5'd1, 3'd0, 12'h100}, 0, 1'b1, 32'h1);
        drain();
        offer(8'h05, 8'h04, 8'hE1, {4'h0, 5'd1, 3'd0, 12'h100}, 0, 1'b1, 32'h1);
        drain();
        // R9 R10: long stall, a second frame offered while busy is ignored
        offer(8'h05, 8'h05, 8'hE1, {4'h0, 5'd9, 3'd3, 12'h3F0}, 20, 1'b1, 32'hCAFE0123);
        repeat (3) @(posedge clk);
        offer(8'h05, 8'h02, 8'hE1, {4'h1, 5'd2, 3'd2, 12'h222}, 0, 1'b1, 32'h55);
        drain();
        // R5 back to back frames
        offer(8'h05, 8'h03, 8'hE1, {4'h0, 5'd4, 3'd4, 12'h444}, 1, 1'b1, 32'h0000BEEF);
        offer(8'h05, 8'h05, 8'hE1, {4'h1, 5'd6, 3'd6, 12'h666}, 0, 1'b1, 32'h89ABCDEF);
        drain();
        offer(8'h05, 8'h05, 8'hE1, {4'h1, 5'd6, 3'd6, 12'h666}, 0, 1'b1, 32'h89ABCDEF);
        drain();

        chk(rq_seen == rq_exp, "R3 R4 R9 request count", 32'(rq_seen), 32'(rq_exp));
        chk(exp_q.size() == 0, "R6 all bytes delivered", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule